// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A controller pulses `start` with the first column of the access and the current mode settings. From the next cycle on, the generator presents one column per enabled clock, raises `beat_valid` while a burst is in flight, and marks the final beat with `burst_done`.

Beats can follow a sequential ordering or an interleaved ordering. Sequential order wraps inside the aligned burst window. Interleaved order XORs the start offset with the beat index. Column bits above the window stay fixed for the whole burst. A full-page burst walks every column of the row and wraps at the row end. Writes can be forced to single-beat bursts. A stop request ends a burst early. A low clock enable freezes the generator. A new start during a burst restarts it from the new column.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `beat_valid`=0, `burst_done`=0, `mode_err`=0 and `col_out`=0.
- R2: An enabled `start` with `len_code` 0, 1, 2 or 3 gives 1, 2, 4 or 8 beats. The first beat shows `start_col` on the cycle after `start`, and each further enabled cycle gives one more beat. `burst_done` is 1 only on the last beat, and `beat_valid` is 0 on the cycle after it.
- R3: With `burst_type`=0, beat i shows the column whose low log2(length) bits equal (start + i) modulo the length. The upper bits are those of `start_col`. For example, length 4 starting at offset 2 gives offsets 2,3,0,1.
- R4: With `burst_type`=1, beat i has low bits equal to the start offset XOR i. The upper bits are those of `start_col`. For example, length 8 starting at 5 gives 5,4,7,6,1,0,3,2.
- R5: `len_code`=7 with `burst_type`=0 gives a 512-beat burst. The column increments by one each beat and wraps from 511 to 0.
- R6: `len_code` 4, 5 or 6, or 7 with `burst_type`=1, gives a single beat and sets `mode_err` from the first beat on. `mode_err` holds until the next start with a valid code clears it.
- R7: When `is_write`=1 and `wr_single`=1 at `start`, the burst is one beat. Reads, and writes with `wr_single`=0, keep the programmed length.
- R8: An enabled `stop` without `start` during a burst makes `beat_valid` 0 on the next cycle, whatever the length.
- R9: While `clk_en` is low at an edge, `col_out`, `beat_valid`, `burst_done`, `mode_err` and the beat position hold. The sequence resumes where it left off once `clk_en` returns.
- R10: An enabled `start` during a burst takes priority over `stop`. The next cycle shows the new `start_col` as beat 0 of a new burst with the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; low freezes all state |
| start | input | 1 | Begin a burst at `start_col` |
| stop | input | 1 | End the current burst early |
| is_write | input | 1 | Burst being started is a write |
| len_code | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| burst_type | input | 1 | 0 sequential, 1 interleaved |
| wr_single | input | 1 | Force writes to one beat |
| start_col | input | 9 | First column of the burst |
| col_out | output | 9 | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| burst_done | output | 1 | Current beat is the last of the burst |
| mode_err | output | 1 | Reserved length/type combination used |

## Verification
A corrupted beat index or window mask shows up on `col_out` on the very next beat. It appears as a column outside the aligned window, or as a sequential-versus-interleaved mismatch. A wrong length or end condition moves `burst_done` off the last beat, or leaves `beat_valid` high one cycle too long. Either shows within a single burst. A clock-enable fault appears as a column that changes during a suspended cycle. A restart fault appears as a stale column on the cycle right after the second `start`.

// File: rtl/sdr_colgen_pkg.sv
package sdr_colgen_pkg;
  typedef enum logic [2:0] {
    LEN_ONE  = 3'd0,
    LEN_TWO  = 3'd1,
    LEN_FOUR = 3'd2,
    LEN_EIGHT= 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/sdr_colgen_mode.sv
module sdr_colgen_mode
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic              order,
  input  logic              is_write,
  input  logic              wr_single,
  output logic [COL_W-1:0]  win_mask,
  output logic              bad_mode
);
  logic [COL_W-1:0] mask_raw;

  always_comb begin
    mask_raw = '0;
    bad_mode = 1'b0;
    case (code)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT:
        mask_raw = (COL_W'(1) << code) - COL_W'(1);
      LEN_PAGE: begin
        if (order == ORD_SEQ) mask_raw = '1;
        else                  bad_mode = 1'b1;
      end
      default: bad_mode = 1'b1;
    endcase
    win_mask = (is_write && wr_single) ? '0 : mask_raw;
  end
endmodule

// File: rtl/sdr_colgen_addr.sv
module sdr_colgen_addr #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] win_mask,
  input  logic             xor_order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + beat;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = win_mask[b] ? (xor_order ? (base[b] ^ beat[b]) : sum[b])
                                : base[b];
  end
endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sdr_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              start,
  input  logic              stop,
  input  logic              is_write,
  input  logic [CODE_W-1:0] len_code,
  input  logic              burst_type,
  input  logic              wr_single,
  input  logic [COL_W-1:0]  start_col,
  output logic [COL_W-1:0]  col_out,
  output logic              beat_valid,
  output logic              burst_done,
  output logic              mode_err
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic [COL_W-1:0] mask_d, mask_q, base_q, beat_q, beat_nx, col_nx;
  logic             err_d, err_q, xor_q, act_q, done_q;
  logic [COL_W-1:0] col_q;

  sdr_colgen_mode #(.COL_W(COL_W), .CODE_W(CODE_W)) u_mode (
    .code     (len_code),
    .order    (burst_type),
    .is_write (is_write),
    .wr_single(wr_single),
    .win_mask (mask_d),
    .bad_mode (err_d)
  );

  assign beat_nx = beat_q + ONE;

  sdr_colgen_addr #(.COL_W(COL_W)) u_addr (
    .base     (base_q),
    .beat     (beat_nx),
    .win_mask (mask_q),
    .xor_order(xor_q),
    .col      (col_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      xor_q  <= 1'b0;
      base_q <= '0;
      mask_q <= '0;
      beat_q <= '0;
      col_q  <= '0;
    end else if (clk_en) begin
      if (start) begin
        act_q  <= 1'b1;
        base_q <= start_col;
        mask_q <= mask_d;
        xor_q  <= burst_type;
        err_q  <= err_d;
        beat_q <= '0;
        col_q  <= start_col;
        done_q <= (mask_d == '0);
      end else if (act_q && (stop || done_q)) begin
        act_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (act_q) begin
        beat_q <= beat_nx;
        col_q  <= col_nx;
        done_q <= (beat_nx == mask_q);
      end
    end
  end

  assign col_out    = col_q;
  assign beat_valid = act_q;
  assign burst_done = done_q;
  assign mode_err   = err_q;
endmodule

// File: rtl/sdr_burst_colgen_chk.sv
module sdr_burst_colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_en,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             beat_valid,
  input logic             burst_done,
  input logic             mode_err
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!beat_valid && !burst_done && !mode_err));

  p_done_in_burst_r2: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> beat_valid);

  p_end_after_done_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_en && burst_done && !start) |=> !beat_valid);

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (clk_en && stop && !start && beat_valid) |=> !beat_valid);

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(col_out) && $stable(beat_valid)
                 && $stable(burst_done) && $stable(mode_err)));

  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (clk_en && start) |=> (beat_valid && col_out == $past(start_col)));
endmodule

bind sdr_burst_colgen sdr_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en    (clk_en),
  .start     (start),
  .stop      (stop),
  .start_col (start_col),
  .col_out   (col_out),
  .beat_valid(beat_valid),
  .burst_done(burst_done),
  .mode_err  (mode_err)
);

// File: tb/sdr_burst_colgen_test.sv
module sdr_burst_colgen_test;
  logic clk = 1'b0, rst = 1'b1, clk_en = 1'b1, start = 1'b0, stop = 1'b0;
  logic is_write = 1'b0, burst_type = 1'b0, wr_single = 1'b0;
  logic [2:0] len_code = 3'd0;
  logic [8:0] start_col = 9'd0, col_out;
  logic beat_valid, burst_done, mode_err;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sdr_burst_colgen uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .start(start), .stop(stop),
    .is_write(is_write), .len_code(len_code), .burst_type(burst_type),
    .wr_single(wr_single), .start_col(start_col), .col_out(col_out),
    .beat_valid(beat_valid), .burst_done(burst_done), .mode_err(mode_err)
  );

  // {err, len[9:0], wr_single, is_write, type, code[2:0], col[8:0]}
  localparam int NV = 12;
  localparam logic [25:0] VECS [NV] = '{
    {1'b0, 10'd1,   1'b0, 1'b0, 1'b0, 3'd0, 9'h0A5},
    {1'b0, 10'd2,   1'b0, 1'b0, 1'b0, 3'd1, 9'h011},
    {1'b0, 10'd4,   1'b0, 1'b0, 1'b0, 3'd2, 9'h0E2},
    {1'b0, 10'd8,   1'b0, 1'b0, 1'b1, 3'd3, 9'h105},
    {1'b0, 10'd4,   1'b0, 1'b0, 1'b1, 3'd2, 9'h03D},
    {1'b0, 10'd8,   1'b0, 1'b0, 1'b0, 3'd3, 9'h1FE},
    {1'b0, 10'd1,   1'b1, 1'b1, 1'b0, 3'd3, 9'h044},
    {1'b0, 10'd8,   1'b0, 1'b1, 1'b0, 3'd3, 9'h044},
    {1'b0, 10'd8,   1'b1, 1'b0, 1'b0, 3'd3, 9'h044},
    {1'b1, 10'd1,   1'b0, 1'b0, 1'b0, 3'd5, 9'h077},
    {1'b1, 10'd1,   1'b0, 1'b0, 1'b1, 3'd7, 9'h078},
    {1'b0, 10'd512, 1'b0, 1'b0, 1'b0, 3'd7, 9'h1FD}
  };

  function automatic int exp_col(int s, int i, int len, bit xo);
    int m = len - 1;
    return (s & ~m & 511) | ((xo ? (s ^ i) : (s + i)) & m);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(int code, bit ty, int col, bit wr, bit ws);
    @(negedge clk);
    len_code = 3'(code); burst_type = ty; start_col = 9'(col);
    is_write = wr; wr_single = ws; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!beat_valid && !burst_done && !mode_err && col_out == 0, "R1 reset",
        {beat_valid, burst_done, mode_err}, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      automatic logic [25:0] e = VECS[v];
      automatic int len = int'(e[24:15]);
      automatic bit xo = e[12];
      automatic int sc = int'(e[8:0]);
      launch(int'(e[11:9]), xo, sc, e[13], e[14]);
      chk(mode_err == e[25], "R6 mode_err", mode_err, e[25]);
      for (int i = 0; i < len; i++) begin
        automatic int ex = exp_col(sc, i, len, xo);
        chk(beat_valid && col_out == 9'(ex),
            len == 512 ? "R5 page column" : (xo ? "R4 xor column" : "R3 seq column"),
            col_out, ex);
        chk(burst_done == (i == len - 1), "R2 done flag", burst_done, i == len - 1);
        if (i != len - 1) @(negedge clk);
      end
      @(negedge clk);
      chk(!beat_valid, e[14] ? "R7 burst length" : "R2 burst end", beat_valid, 0);
    end

    // R8: early stop during an 8-beat burst
    launch(3, 1'b0, 9'h020, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    chk(col_out == 9'h022, "R8 pre-stop column", col_out, 9'h022);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!beat_valid && !burst_done, "R8 stop", beat_valid, 0);

    // R9: clock suspend freezes the burst
    launch(3, 1'b1, 9'h043, 1'b0, 1'b0);
    @(negedge clk);
    chk(col_out == 9'h042, "R9 before freeze", col_out, 9'h042);
    clk_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(beat_valid && col_out == 9'h042 && !burst_done, "R9 frozen", col_out, 9'h042);
    end
    stop = 1'b1;
    @(negedge clk);
    chk(beat_valid && col_out == 9'h042, "R9 stop ignored while frozen", col_out, 9'h042);
    stop = 1'b0; clk_en = 1'b1;
    @(negedge clk);
    chk(col_out == 9'h041, "R9 resume", col_out, 9'h041);

    // R10: restart mid-burst, start wins over stop
    launch(3, 1'b0, 9'h000, 1'b0, 1'b0);
    @(negedge clk);
    len_code = 3'd2; burst_type = 1'b0; start_col = 9'h1F3;
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      automatic int ex = exp_col(9'h1F3, i, 4, 1'b0);
      chk(beat_valid && col_out == 9'(ex), "R10 restart column", col_out, ex);
      @(negedge clk);
    end
    chk(!beat_valid, "R10 restart length", beat_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule